// File: doc/BRIEF.md
# Watchdog Reset Gating Controller

This block sits in the always-on domain between a watchdog timer and the system reset. It decides whether a reset request from the watchdog reaches the system. A gate bit can be set to block the request. An auto-suppress bit drops the request while the associated processor is itself held in reset. The block also drives the run-enable that lets the watchdog counter advance.

Every forwarded reset is stretched into a registered pulse of fixed length. A sticky cause bit records whether the most recent forwarded reset came from the watchdog or from the single external reset input. The block is not reset by its own output, so the cause bit survives the reset it reports.

Software reaches the bits over a simple single-cycle register bus. Each write carries a per-bit write mask, so one field can be changed without disturbing any other.

Top module: `wdt_rst_gate`

## Requirements
- R1: After `rst_ni` is released, every register reads 0 and both `sys_rst_o` and `cnt_en_o` are 0.
- R2: Each register has one implemented bit. The gate bit is at word 0, bit `MASK_BIT`. The auto-suppress bit is at word 1, bit `AUTO_BIT`. The counter-run bit is at word 2, bit `CNT_EN_BIT`. The cause bit is at word 3, bit `CAUSE_BIT`. All other bits, and all words at index 4 and above, read 0. `rdata_o` is 0 unless `req_i=1` and `we_i=0`.
- R3: A write with `req_i=1`, `we_i=1` changes a writable bit only when the same position in `bitmask_i` is 1.
- R4: `cnt_en_o` equals the stored counter-run bit, and follows a write on the next clock edge.
- R5: With `INV_POL=0`, a gate bit of 1 blocks the watchdog request. With `INV_POL=1`, a gate bit of 1 lets the request through and 0 blocks it.
- R6: While the auto-suppress bit is 1 and `cpu_in_reset_i` is 1, a watchdog request is dropped. While the bit is 0, `cpu_in_reset_i` has no effect.
- R7: A forwarded request sampled at a clock edge raises `sys_rst_o` at that edge. It then holds it high for exactly `PULSE_LEN` cycles.
- R8: Requests of either source that arrive while `sys_rst_o` is high are ignored. They neither stretch the pulse nor change the cause bit.
- R9: The cause bit is set when a watchdog request starts a pulse and cleared when an external request alone starts one. If both start it on the same edge, it is set. Otherwise it changes only on `rst_ni`, and bus writes to it have no effect.
- R10: `ext_rst_i` starts a pulse whenever no pulse is in progress, whatever the gate and auto-suppress bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | ADDR_W | Register word index |
| wdata_i | input | DATA_W | Write data |
| bitmask_i | input | DATA_W | Per-bit write mask |
| rdata_o | output | DATA_W | Read data, combinational |
| wdt_req_i | input | 1 | Reset request from the watchdog |
| cpu_in_reset_i | input | 1 | Associated processor is held in reset |
| ext_rst_i | input | 1 | External reset request |
| cnt_en_o | output | 1 | Lets the watchdog counter run |
| sys_rst_o | output | 1 | Stretched system reset pulse |

## Verification
The hardest situation to reach is a request from one source landing while a pulse from the other is still running. A single instance almost never lines these up from its ports.

The bench builds two instances of opposite gate polarity that share every input. Writing a single gate value therefore leaves one instance open and the other closed. A watchdog request then opens a pulse in one instance only. An external request placed on the following edges is dropped by the busy instance and taken by the idle one. The same shared stimulus also covers a simultaneous watchdog and external request, and long random runs give further collisions.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  typedef enum logic [1:0] {
    SLOT_MASK  = 2'd0,
    SLOT_AUTO  = 2'd1,
    SLOT_CNTEN = 2'd2,
    SLOT_CAUSE = 2'd3
  } wrg_slot_e;

  localparam int NUM_CTRL  = 3;
  localparam int NUM_SLOTS = 4;

  // bit order matches the slot index of each writable field
  typedef struct packed {
    logic cnt_en;
    logic auto_dis;
    logic mask;
  } wrg_ctrl_t;
endpackage

// File: rtl/wrg_regs.sv
module wrg_regs
  import wrg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int MASK_BIT   = 2,
  parameter int AUTO_BIT   = 0,
  parameter int CNT_EN_BIT = 7,
  parameter int CAUSE_BIT  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bitmask_i,
  input  logic              cause_i,
  output wrg_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_CTRL-1:0]  ctrl_bits;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      hit[s] = req_i && (addr_i == ADDR_W'(s));
    end
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_fld
    localparam int POS = (g == 0) ? MASK_BIT : ((g == 1) ? AUTO_BIT : CNT_EN_BIT);
    logic bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else if (hit[g] && we_i && bitmask_i[POS]) begin
        bit_q <= wdata_i[POS];
      end
    end

    assign ctrl_bits[g] = bit_q;
  end

  assign ctrl_o = wrg_ctrl_t'(ctrl_bits);

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit[SLOT_MASK])  rdata_o[MASK_BIT]   = ctrl_bits[0];
      if (hit[SLOT_AUTO])  rdata_o[AUTO_BIT]   = ctrl_bits[1];
      if (hit[SLOT_CNTEN]) rdata_o[CNT_EN_BIT] = ctrl_bits[2];
      if (hit[SLOT_CAUSE]) rdata_o[CAUSE_BIT]  = cause_i;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i, bitmask_i};
endmodule

// File: rtl/wrg_gate.sv
module wrg_gate #(
  parameter bit INV_POL = 1'b0
) (
  input  logic wdt_req_i,
  input  logic cpu_in_reset_i,
  input  logic mask_i,
  input  logic auto_dis_i,
  output logic pass_o
);
  logic gate_open;

  if (INV_POL) begin : g_inv
    assign gate_open = mask_i;
  end else begin : g_dir
    assign gate_open = ~mask_i;
  end

  assign pass_o = wdt_req_i & gate_open & ~(auto_dis_i & cpu_in_reset_i);
endmodule

// File: rtl/wrg_pulse.sv
module wrg_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_pass_i,
  input  logic ext_rst_i,
  output logic sys_rst_o,
  output logic cause_set_o,
  output logic cause_clr_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;
  logic             idle;
  logic             trig;

  assign idle = (cnt_q == '0);
  assign trig = idle & (wdt_pass_i | ext_rst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= trig | (cnt_q > CNT_W'(1));
      if (trig) begin
        cnt_q <= CNT_W'(PULSE_LEN);
      end else if (!idle) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sys_rst_o   = rst_q;
  assign cause_set_o = trig & wdt_pass_i;
  assign cause_clr_o = trig & ~wdt_pass_i;
endmodule

// File: rtl/wrg_cause.sv
module wrg_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic cause_o
);
  logic cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= 1'b0;
    end else if (set_i) begin
      cause_q <= 1'b1;
    end else if (clr_i) begin
      cause_q <= 1'b0;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate
  import wrg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int MASK_BIT   = 2,
  parameter int AUTO_BIT   = 0,
  parameter int CNT_EN_BIT = 7,
  parameter int CAUSE_BIT  = 0,
  parameter bit INV_POL    = 1'b0,
  parameter int PULSE_LEN  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bitmask_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wdt_req_i,
  input  logic              cpu_in_reset_i,
  input  logic              ext_rst_i,
  output logic              cnt_en_o,
  output logic              sys_rst_o
);
  wrg_ctrl_t ctrl;
  logic      mask_q;
  logic      auto_q;
  logic      cause_q;
  logic      wdt_pass;
  logic      cause_set;
  logic      cause_clr;

  wrg_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MASK_BIT  (MASK_BIT),
    .AUTO_BIT  (AUTO_BIT),
    .CNT_EN_BIT(CNT_EN_BIT),
    .CAUSE_BIT (CAUSE_BIT)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .bitmask_i(bitmask_i),
    .cause_i  (cause_q),
    .ctrl_o   (ctrl),
    .rdata_o  (rdata_o)
  );

  assign mask_q   = ctrl.mask;
  assign auto_q   = ctrl.auto_dis;
  assign cnt_en_o = ctrl.cnt_en;

  wrg_gate #(
    .INV_POL(INV_POL)
  ) u_gate (
    .wdt_req_i     (wdt_req_i),
    .cpu_in_reset_i(cpu_in_reset_i),
    .mask_i        (mask_q),
    .auto_dis_i    (auto_q),
    .pass_o        (wdt_pass)
  );

  wrg_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdt_pass_i (wdt_pass),
    .ext_rst_i  (ext_rst_i),
    .sys_rst_o  (sys_rst_o),
    .cause_set_o(cause_set),
    .cause_clr_o(cause_clr)
  );

  wrg_cause u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cause_set),
    .clr_i  (cause_clr),
    .cause_o(cause_q)
  );
endmodule

// File: rtl/wrg_chk.sv
module wrg_chk
  import wrg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int CNT_EN_BIT = 7,
  parameter bit INV_POL    = 1'b0,
  parameter int PULSE_LEN  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] bitmask_i,
  input logic              wdt_req_i,
  input logic              cpu_in_reset_i,
  input logic              ext_rst_i,
  input logic              sys_rst_o,
  input logic              cnt_en_o,
  input logic              mask_q,
  input logic              auto_q,
  input logic              cause_q
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_cnt <= '0;
    else if (!sys_rst_o) run_cnt <= '0;
    else                run_cnt <= run_cnt + 1'b1;
  end

  assert_pulse_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (run_cnt < RUN_W'(PULSE_LEN)));

  assert_pulse_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (run_cnt == RUN_W'(PULSE_LEN)));

  assert_cnt_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(SLOT_CNTEN) && bitmask_i[CNT_EN_BIT])
      |=> (cnt_en_o == $past(wdata_i[CNT_EN_BIT])));

  assert_gate_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && !ext_rst_i && (INV_POL ? !mask_q : mask_q)) |=> !sys_rst_o);

  assert_auto_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && !ext_rst_i && auto_q && cpu_in_reset_i) |=> !sys_rst_o);

  assert_ext_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && ext_rst_i) |=> sys_rst_o);

  assert_cause_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sys_rst_o) |-> $stable(cause_q));

  assert_cause_wdt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && !$past(ext_rst_i)) |-> cause_q);

  assert_cause_ext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && $past(ext_rst_i) && !$past(wdt_req_i)) |-> !cause_q);

  logic unused_chk;
  assign unused_chk = ^{wdata_i, bitmask_i};
endmodule

bind wdt_rst_gate wrg_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .CNT_EN_BIT(CNT_EN_BIT),
  .INV_POL   (INV_POL),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .bitmask_i     (bitmask_i),
  .wdt_req_i     (wdt_req_i),
  .cpu_in_reset_i(cpu_in_reset_i),
  .ext_rst_i     (ext_rst_i),
  .sys_rst_o     (sys_rst_o),
  .cnt_en_o      (cnt_en_o),
  .mask_q        (mask_q),
  .auto_q        (auto_q),
  .cause_q       (cause_q)
);

// File: tb/sim_wdt_rst_gate.sv
module sim_wdt_rst_gate;
  localparam int DW   = 32;
  localparam int AW   = 3;
  localparam int MB   = 2;
  localparam int AB   = 4;
  localparam int CB   = 7;
  localparam int XB   = 0;
  localparam int PLEN = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] bmask = '0;
  logic          wdt_req = 1'b0;
  logic          cpu_rst = 1'b0;
  logic          ext_rst = 1'b0;
  logic [DW-1:0] rdata0, rdata1;
  logic          cen0, cen1, sys0, sys1;

  int n_chk = 0;
  int n_err = 0;

  // model state, index 0: direct polarity, index 1: inverted polarity
  int   m_cnt[2];
  logic m_mask[2];
  logic m_auto[2];
  logic m_cen[2];
  logic m_cause[2];

  always #2 clk = ~clk;

  wdt_rst_gate #(.DATA_W(DW), .ADDR_W(AW), .MASK_BIT(MB), .AUTO_BIT(AB),
    .CNT_EN_BIT(CB), .CAUSE_BIT(XB), .INV_POL(1'b0), .PULSE_LEN(PLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .bitmask_i(bmask), .rdata_o(rdata0), .wdt_req_i(wdt_req),
    .cpu_in_reset_i(cpu_rst), .ext_rst_i(ext_rst), .cnt_en_o(cen0), .sys_rst_o(sys0));

  wdt_rst_gate #(.DATA_W(DW), .ADDR_W(AW), .MASK_BIT(MB), .AUTO_BIT(AB),
    .CNT_EN_BIT(CB), .CAUSE_BIT(XB), .INV_POL(1'b1), .PULSE_LEN(PLEN)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .bitmask_i(bmask), .rdata_o(rdata1), .wdt_req_i(wdt_req),
    .cpu_in_reset_i(cpu_rst), .ext_rst_i(ext_rst), .cnt_en_o(cen1), .sys_rst_o(sys1));

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_mask[i] = 0; m_auto[i] = 0; m_cen[i] = 0; m_cause[i] = 0;
    end
  endtask

  function automatic logic m_open(int i);
    return (i == 1) ? m_mask[i] : !m_mask[i];
  endfunction

  function automatic logic [DW-1:0] exp_rd(int i, int a);
    logic [DW-1:0] r = '0;
    case (a)
      0: r[MB] = m_mask[i];
      1: r[AB] = m_auto[i];
      2: r[CB] = m_cen[i];
      3: r[XB] = m_cause[i];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      logic pass;
      pass = wdt_req && m_open(i) && !(m_auto[i] && cpu_rst);
      if ((pass || ext_rst) && m_cnt[i] == 0) begin
        m_cnt[i]   = PLEN;
        m_cause[i] = pass;
      end else if (m_cnt[i] > 0) begin
        m_cnt[i]--;
      end
      if (req && we) begin
        if (addr == 0 && bmask[MB]) m_mask[i] = wdata[MB];
        if (addr == 1 && bmask[AB]) m_auto[i] = wdata[AB];
        if (addr == 2 && bmask[CB]) m_cen[i]  = wdata[CB];
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R7 sys u0", DW'(sys0), DW'(m_cnt[0] != 0));
    chk("R7 sys u1", DW'(sys1), DW'(m_cnt[1] != 0));
    chk("R4 cnt_en u0", DW'(cen0), DW'(m_cen[0]));
    chk("R4 cnt_en u1", DW'(cen1), DW'(m_cen[1]));
  endtask

  task automatic rd(string tag, int a, logic [DW-1:0] e0, logic [DW-1:0] e1);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #1;
    chk(tag, rdata0, e0);
    chk(tag, rdata1, e1);
    tick();
    req = 1'b0;
  endtask

  task automatic wr(int a, logic [DW-1:0] m, logic [DW-1:0] d);
    req = 1'b1; we = 1'b1; addr = AW'(a); bmask = m; wdata = d;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic count_pulse(output int n0, output int n1);
    n0 = 0; n1 = 0;
    for (int k = 0; k < 8; k++) begin
      if (sys0) n0++;
      if (sys1) n1++;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int n0, n1;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 sys in reset", DW'({sys0, sys1}), '0);
    rst_ni = 1'b1;
    chk("R1 outputs", DW'({sys0, sys1, cen0, cen1}), '0);
    for (int a = 0; a < 8; a++) rd("R1 regs", a, '0, '0);

    // R2: single implemented bit, read-only cause, unmapped words
    wr(0, '1, '1);
    rd("R2 gate bit", 0, DW'(1) << MB, DW'(1) << MB);
    wr(5, '1, '1);
    rd("R2 unmapped", 5, '0, '0);
    wr(3, '1, '1);
    rd("R9 cause write ignored", 3, '0, '0);
    req = 1'b1; we = 1'b1; addr = AW'(1); #1;
    chk("R2 write cycle reads zero", rdata0, '0);
    req = 1'b0; we = 1'b0;
    wr(0, '1, '0);

    // R3: bitmask gating
    wr(1, ~(DW'(1) << AB), '1);
    rd("R3 masked write", 1, '0, '0);
    wr(1, DW'(1) << AB, '1);
    rd("R3 unmasked write", 1, DW'(1) << AB, DW'(1) << AB);
    wr(1, ~(DW'(1) << AB), '0);
    rd("R3 masked clear", 1, DW'(1) << AB, DW'(1) << AB);
    wr(1, DW'(1) << AB, '0);

    // R4: counter run output
    wr(2, DW'(1) << CB, DW'(1) << CB);
    chk("R4 cnt_en set", DW'({cen0, cen1}), DW'(2'b11));

    // R5/R7: gate bit 0 -> u0 open, u1 closed
    wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    count_pulse(n0, n1);
    chk("R7 pulse length u0", DW'(n0), DW'(PLEN));
    chk("R5 inverted closed u1", DW'(n1), '0);
    rd("R9 cause after wdt", 3, DW'(1) << XB, '0);

    wr(0, DW'(1) << MB, DW'(1) << MB);
    wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    count_pulse(n0, n1);
    chk("R5 direct blocked u0", DW'(n0), '0);
    chk("R7 pulse length u1", DW'(n1), DW'(PLEN));
    rd("R9 cause held", 3, DW'(1) << XB, DW'(1) << XB);

    // R8/R10: external request during u1 pulse; u0 idle takes it
    wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    ext_rst = 1'b1;
    n0 = 0; n1 = 0;
    for (int k = 0; k < 10; k++) begin
      if (sys0) n0++;
      if (sys1) n1++;
      if (k == 1) ext_rst = 1'b0;
      tick();
    end
    chk("R8 no stretch u1", DW'(n1), DW'(PLEN));
    chk("R10 ext bypasses gate u0", DW'(n0), DW'(PLEN));
    rd("R8,R10 cause", 3, '0, DW'(1) << XB);

    // R6: auto-suppress
    wr(1, DW'(1) << AB, DW'(1) << AB);
    cpu_rst = 1'b1; wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    chk("R6 dropped in cpu reset", DW'(sys1), '0);
    repeat (2) tick();
    cpu_rst = 1'b0; wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    chk("R6 passes cpu running", DW'(sys1), 1);
    repeat (8) tick();
    wr(1, DW'(1) << AB, '0);
    cpu_rst = 1'b1; wdt_req = 1'b1; tick(); wdt_req = 1'b0; cpu_rst = 1'b0;
    chk("R6 no effect when clear", DW'(sys1), 1);
    repeat (8) tick();

    // R9: both sources on one edge
    wdt_req = 1'b1; ext_rst = 1'b1; tick(); wdt_req = 1'b0; ext_rst = 1'b0;
    chk("R9 both start pulse", DW'({sys0, sys1}), DW'(2'b11));
    repeat (8) tick();
    rd("R9 simultaneous cause", 3, '0, DW'(1) << XB);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int op, a;
      op = $urandom % 4;
      a  = $urandom % 8;
      wdt_req = (($urandom % 4) == 0);
      ext_rst = (($urandom % 32) == 0);
      cpu_rst = $urandom % 2;
      if (op == 0)      wr(a, $urandom, $urandom);
      else if (op == 1) rd("R2 random read", a, exp_rd(0, a), exp_rd(1, a));
      else              tick();
    end
    wdt_req = 1'b0; ext_rst = 1'b0; cpu_rst = 1'b0;

    // power-on reset clears sticky cause
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1 sys cleared", DW'({sys0, sys1}), '0);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) rd("R1 R9 after power-on", a, '0, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule